// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries data words from a producer running on one clock to a consumer running on an unrelated clock. The producer raises a write request with a word whenever the full flag is low. The consumer sees the oldest stored word on the read data output as soon as the empty flag falls. It takes that word and raises a read request in the same cycle to step to the next one.

Storage is a register array of 2^ADDR_W words. Each side keeps a binary pointer one bit wider than the address, plus a Gray copy of that pointer. Only the Gray copy is passed to the other clock domain, through a two-stage synchronizer. The full flag is computed in the write domain from the write pointer's next value and the synchronized read pointer. The empty flag is computed in the read domain in the same way. Each flag therefore sets at once when its own side causes it. It clears a few of its own cycles after the other side moves. ADDR_W must be at least 2.

Top module: `dcfifo_gray`

## Requirements
- R1: Once both resets have been released and before any write, the empty flag reads 1 and the full flag reads 0.
- R2: Under arbitrary request patterns on both sides, every accepted word is read exactly once, in the order it was written, with no loss and no duplication.
- R3: Whenever the empty flag is 0, the read data output already shows the oldest unread word, with no read request needed first.
- R4: A write request while the full flag is 1 is ignored: no stored word is overwritten and the full flag stays 1.
- R5: A read request while the empty flag is 1 is ignored: the empty flag stays 1 and the read pointer does not advance, so the next word written is the next word read.
- R6: With no reads, exactly 2^ADDR_W writes are accepted. The full flag is 1 in the write cycle that directly follows the accepted write that fills the last location.
- R7: The empty flag is 1 in the read cycle that directly follows the read that takes the last stored word.
- R8: Pointers cross domains as Gray codes that change by exactly one bit per step. After the opposite side frees a location or adds a word, full or empty clears within 8 cycles of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| wrst_ni | input | 1 | Write-side asynchronous reset, active low |
| wreq_i | input | 1 | Write request; accepted when wfull_o is 0 |
| wdata_i | input | DATA_W | Word to store |
| wfull_o | output | 1 | FIFO full, write clock domain |
| rclk_i | input | 1 | Read-side clock |
| rrst_ni | input | 1 | Read-side asynchronous reset, active low |
| rreq_i | input | 1 | Read request; pops the head word when rempty_o is 0 |
| rdata_o | output | DATA_W | Oldest unread word, valid while rempty_o is 0 |
| rempty_o | output | 1 | FIFO empty, read clock domain |

## Verification
On every cycle, the assertions check several invariants. The write-side occupancy, measured against the synchronized read pointer, never exceeds the depth, and the read side never passes the synchronized write pointer. Each Gray pointer changes by a single bit. A flag that is set stays set until the opposite pointer moves through its synchronizer. Only the bench's scenarios can show the end-to-end results: word ordering while the two clocks drift against each other, fall-through visibility of the head word, the exact capacity, the cycle in which each flag sets, and the bounded delay before it clears.

// File: rtl/cdc_fifo_pkg.sv
`timescale 1ns/1ps
package cdc_fifo_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/cdc_sync.sv
`timescale 1ns/1ps
module cdc_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fifo_wr_ctrl.sv
`timescale 1ns/1ps
module fifo_wr_ctrl
  import cdc_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        wclk_i,
  input  logic        wrst_ni,
  input  logic        wreq_i,
  input  logic [AW:0] rgray_sync_i,
  output logic        wen_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0] wgray_o,
  output logic        wfull_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin_q, wgray_q, wbin_nxt, wgray_nxt, rgray_far;
  logic          wfull_q, wen;

  assign wen       = wreq_i & ~wfull_q;
  assign wbin_nxt  = wbin_q + PW'(wen);
  assign wgray_nxt = PW'(bin2gray(32'(wbin_nxt)));
  // read pointer one lap behind: top two Gray bits flipped
  assign rgray_far = {~rgray_sync_i[PW-1:PW-2], rgray_sync_i[PW-3:0]};

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      wfull_q <= 1'b0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wgray_nxt;
      wfull_q <= (wgray_nxt == rgray_far);
    end
  end

  assign wen_o   = wen;
  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign wfull_o = wfull_q;

  // R4
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (wbin_q - PW'(gray2bin(32'(rgray_sync_i)))) <= PW'(DEPTH));
  // R6
  full_hold_chk: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (wfull_q && $stable(rgray_sync_i)) |=> wfull_q);
  // R8
  wgray_step_chk: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    !$stable(wgray_q) |-> ($countones(wgray_q ^ $past(wgray_q)) == 1));
endmodule

// File: rtl/fifo_rd_ctrl.sv
`timescale 1ns/1ps
module fifo_rd_ctrl
  import cdc_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        rclk_i,
  input  logic        rrst_ni,
  input  logic        rreq_i,
  input  logic [AW:0] wgray_sync_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0] rgray_o,
  output logic        rempty_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin_q, rgray_q, rbin_nxt, rgray_nxt;
  logic          rempty_q, ren;

  assign ren       = rreq_i & ~rempty_q;
  assign rbin_nxt  = rbin_q + PW'(ren);
  assign rgray_nxt = PW'(bin2gray(32'(rbin_nxt)));

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      rempty_q <= 1'b1;
    end else begin
      rbin_q   <= rbin_nxt;
      rgray_q  <= rgray_nxt;
      rempty_q <= (rgray_nxt == wgray_sync_i);
    end
  end

  assign raddr_o  = rbin_q[AW-1:0];
  assign rgray_o  = rgray_q;
  assign rempty_o = rempty_q;

  // R5
  no_underflow_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (PW'(gray2bin(32'(wgray_sync_i))) - rbin_q) <= PW'(DEPTH));
  // R7
  empty_hold_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (rempty_q && $stable(wgray_sync_i)) |=> rempty_q);
  // R8
  rgray_step_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !$stable(rgray_q) |-> ($countones(rgray_q ^ $past(rgray_q)) == 1));
endmodule

// File: rtl/fifo_store.sv
`timescale 1ns/1ps
module fifo_store #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          wen_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (wen_i) mem_q[waddr_i] <= wdata_i;
  end

  // fall-through: head word visible without a read cycle
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcfifo_gray.sv
`timescale 1ns/1ps
module dcfifo_gray #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              wreq_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wfull_o,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              rreq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rempty_o
);
  localparam int PW = ADDR_W + 1;

  logic              wen;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;

  fifo_wr_ctrl #(.AW(ADDR_W)) i_wr_ctrl (
    .wclk_i       (wclk_i),
    .wrst_ni      (wrst_ni),
    .wreq_i       (wreq_i),
    .rgray_sync_i (rgray_ws),
    .wen_o        (wen),
    .waddr_o      (waddr),
    .wgray_o      (wgray),
    .wfull_o      (wfull_o)
  );

  fifo_rd_ctrl #(.AW(ADDR_W)) i_rd_ctrl (
    .rclk_i       (rclk_i),
    .rrst_ni      (rrst_ni),
    .rreq_i       (rreq_i),
    .wgray_sync_i (wgray_rs),
    .raddr_o      (raddr),
    .rgray_o      (rgray),
    .rempty_o     (rempty_o)
  );

  cdc_sync #(.W(PW)) i_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rrst_ni),
    .d_i    (wgray),
    .q_o    (wgray_rs)
  );

  cdc_sync #(.W(PW)) i_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (wrst_ni),
    .d_i    (rgray),
    .q_o    (rgray_ws)
  );

  fifo_store #(.DW(DATA_W), .AW(ADDR_W)) i_store (
    .wclk_i  (wclk_i),
    .wen_i   (wen),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (rdata_o)
  );
endmodule

// File: tb/test_dcfifo_gray.sv
`timescale 1ns/1ps
module test_dcfifo_gray;
  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wrst_n, rrst_n, wreq, rreq;
  logic [DW-1:0] wdata, rdata;
  logic          wfull, rempty;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;
  logic [DW-1:0] sb[$];

  always #4   wclk = ~wclk;   // 125 MHz
  always #5.3 rclk = ~rclk;   // unrelated read clock

  dcfifo_gray #(.DATA_W(DW), .ADDR_W(AW)) i_dcfifo_gray (
    .wclk_i   (wclk),
    .wrst_ni  (wrst_n),
    .wreq_i   (wreq),
    .wdata_i  (wdata),
    .wfull_o  (wfull),
    .rclk_i   (rclk),
    .rrst_ni  (rrst_n),
    .rreq_i   (rreq),
    .rdata_o  (rdata),
    .rempty_o (rempty)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // accepted = request while full is low at the negedge before the edge
  task automatic writer(input int n_words, input int pct);
    int got = 0;
    while (got < n_words) begin
      @(negedge wclk);
      if ($urandom_range(99) < pct) begin
        wreq  = 1'b1;
        wdata = $urandom;
        if (!wfull) begin
          sb.push_back(wdata);
          got++;
        end
      end else begin
        wreq = 1'b0;
      end
    end
    @(negedge wclk);
    wreq = 1'b0;
  endtask

  task automatic reader(input int n_words, input int pct);
    int got = 0;
    while (got < n_words) begin
      @(negedge rclk);
      if (!rempty) begin
        if (sb.size() == 0) check(1'b0, "R2 unexpected word", rdata, '0);
        else check(rdata == sb[0], "R2 order", rdata, sb[0]);
      end
      if ($urandom_range(99) < pct) begin
        rreq = 1'b1;
        if (!rempty && sb.size() > 0) begin
          void'(sb.pop_front());
          got++;
        end
      end else begin
        rreq = 1'b0;
      end
    end
    @(negedge rclk);
    rreq = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [DW-1:0] probe;
    void'($urandom(32'd20240611));
    wrst_n = 1'b0; rrst_n = 1'b0;
    wreq = 1'b0; rreq = 1'b0; wdata = '0;
    repeat (3) @(negedge wclk);
    wrst_n = 1'b1;
    @(negedge rclk);
    rrst_n = 1'b1;
    repeat (2) @(negedge rclk);
    check(rempty == 1'b1, "R1 empty after reset", 32'(rempty), 32'd1);
    @(negedge wclk);
    check(wfull == 1'b0, "R1 not full after reset", 32'(wfull), 32'd0);

    // R6: fill to capacity with reads stalled
    writer(DEPTH, 100);
    check(wfull == 1'b1, "R6 full right after last write", 32'(wfull), 32'd1);
    check(sb.size() == DEPTH, "R6 capacity", 32'(sb.size()), 32'(DEPTH));
    // R4: writes while full are dropped
    for (int i = 0; i < 5; i++) begin
      wreq  = 1'b1;
      wdata = 32'hdead_0000 + 32'(i);
      @(negedge wclk);
      check(wfull == 1'b1, "R4 full holds under write", 32'(wfull), 32'd1);
    end
    wreq = 1'b0;

    // R8: full clears after one read crosses
    reader(1, 100);
    lat = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge wclk);
      if (!wfull) break;
      lat++;
    end
    check(lat <= 8, "R8 full release latency", 32'(lat), 32'd8);

    // drain; stored words must be the first DEPTH, not the dropped ones (R4)
    reader(DEPTH - 1, 100);
    check(rempty == 1'b1, "R7 empty right after last read", 32'(rempty), 32'd1);
    check(sb.size() == 0, "R4 no extra word stored", 32'(sb.size()), 32'd0);

    // R5: reads while empty are ignored
    for (int i = 0; i < 5; i++) begin
      rreq = 1'b1;
      @(negedge rclk);
      check(rempty == 1'b1, "R5 empty holds under read", 32'(rempty), 32'd1);
    end
    rreq = 1'b0;

    writer(1, 100);
    probe = sb[0];
    lat = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge rclk);
      if (!rempty) break;
      lat++;
    end
    check(lat <= 8, "R8 empty release latency", 32'(lat), 32'd8);
    check(rdata == probe, "R3 R5 head word visible without read", rdata, probe);
    reader(1, 100);
    check(rempty == 1'b1, "R7 empty after single read", 32'(rempty), 32'd1);

    // R2: random traffic, full-heavy, empty-heavy, balanced
    fork
      writer(400, 85);
      reader(400, 30);
    join
    fork
      writer(400, 25);
      reader(400, 90);
    join
    fork
      writer(400, 60);
      reader(400, 60);
    join
    repeat (10) @(negedge rclk);
    check(rempty == 1'b1, "R2 empty after all words", 32'(rempty), 32'd1);
    check(sb.size() == 0, "R2 no word lost", 32'(sb.size()), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule